// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits at the execute stage of a five-stage in-order pipeline and picks, for each of the two ALU source operands, the freshest copy of the source register. There are three candidates. The first is the value read from the register file and held in the decode/execute register. The second is the result waiting in the execute/memory register. The third is the result waiting in the memory/writeback register. The block compares each operand's source register number with the destination numbers and write flags of the two later stages. From that comparison it produces a 2-bit select code per operand and drives the selected value out through its own 3-input multiplexer.

The unit is purely combinational and has no clock or reset. Every input is a plain control or data pin: the values arrive already latched in the pipeline registers around the block, so there is no valid/ready handshake and no back-pressure. Each output follows its inputs in the same cycle, and the surrounding pipeline registers decide when a result is used. Register numbers are 5 bits wide and data is 32 bits wide, both set by parameters.

Top module: `fwd_unit`

## Requirements
- R1: The select code of each operand is 2'b00 for the register-file value, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback result, and the operand output equals the value that its select code names.
- R2: An operand takes the execute/memory result only when that stage's write flag is 1, its destination is nonzero, and its destination equals the operand's source register number.
- R3: An operand takes the memory/writeback result only when that stage's write flag is 1, its destination is nonzero, its destination equals the operand's source register number, and the execute/memory stage does not also qualify under R2.
- R4: Operand A compares only against the first source number (rs_a) and operand B compares only against the second (rs_b), and each operand gets its own select code.
- R5: A destination of register 0 never causes forwarding from either stage, even when that stage's write flag is 1.
- R6: When both later stages qualify for the same operand, the execute/memory result wins (select 2'b10).
- R7: The select code 2'b11 is never produced. If the multiplexer ever sees 2'b11, it passes the register-file value.
- R8: The select codes and operand outputs are combinational and follow a change on any input within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_a | input | 5 | Source register number of operand A (first source field) |
| rs_b | input | 5 | Source register number of operand B (second source field) |
| exm_rd | input | 5 | Destination register number held in the execute/memory register |
| exm_we | input | 1 | Register-write flag of the execute/memory stage |
| mwb_rd | input | 5 | Destination register number held in the memory/writeback register |
| mwb_we | input | 1 | Register-write flag of the memory/writeback stage |
| rf_a | input | 32 | Register-file value for operand A from the decode/execute register |
| rf_b | input | 32 | Register-file value for operand B from the decode/execute register |
| exm_val | input | 32 | Result held in the execute/memory register |
| mwb_val | input | 32 | Result held in the memory/writeback register |
| sel_a | output | 2 | Select code of operand A |
| sel_b | output | 2 | Select code of operand B |
| op_a | output | 32 | Forwarded value of operand A |
| op_b | output | 32 | Forwarded value of operand B |

## Verification
The immediate assertions are evaluated whenever an input changes. They check that the code 2'b11 never appears, that a forward from either stage always has a nonzero destination with its write flag set, that a double match resolves to the execute/memory stage, and that each operand output carries the value its select code names. Other behaviour is visible only in the bench's scenarios. These include that a matching producer is not missed, that rs_a and rs_b are not swapped, and the ordering effects of a back-to-back dependency, a dependency two instructions apart, a double match and writes aimed at register 0. The bench checks them against a reference model that it builds from the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10,
    SEL_BAD = 2'b11
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic             we,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    hit = we && (rd != ZERO_REG) && (rd == rs);
  end

  // R5: a hit never names register 0
  always_comb begin
    if (hit) a_r5_no_zero_hit : assert (rd != ZERO_REG && we);
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
(
  input  logic     exm_hit,
  input  logic     mwb_hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (exm_hit)      sel = SEL_EXM;
    else if (mwb_hit) sel = SEL_MWB;
    else              sel = SEL_RF;
  end

  always_comb begin
    if (exm_hit && mwb_hit) a_r6_newest_wins : assert (sel == SEL_EXM);
    a_r7_no_code11 : assert (sel != SEL_BAD);
  end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [DATA_W-1:0] op
);
  always_comb begin
    unique case (sel)
      SEL_EXM: op = exm_val;
      SEL_MWB: op = mwb_val;
      SEL_RF:  op = rf_val;
      default: op = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  rs_a,
  input  logic [REG_W-1:0]  rs_b,
  input  logic [REG_W-1:0]  exm_rd,
  input  logic              exm_we,
  input  logic [REG_W-1:0]  mwb_rd,
  input  logic              mwb_we,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  localparam int N_OPS = 2;

  logic [REG_W-1:0]  rs_vec [N_OPS];
  logic [DATA_W-1:0] rf_vec [N_OPS];
  logic [DATA_W-1:0] op_vec [N_OPS];
  fwd_sel_e          sel_vec[N_OPS];

  assign rs_vec[0] = rs_a;
  assign rs_vec[1] = rs_b;
  assign rf_vec[0] = rf_a;
  assign rf_vec[1] = rf_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    logic exm_hit;
    logic mwb_hit;

    fwd_match #(.REG_W(REG_W)) u_exm_match (
      .we(exm_we), .rd(exm_rd), .rs(rs_vec[g]), .hit(exm_hit)
    );
    fwd_match #(.REG_W(REG_W)) u_mwb_match (
      .we(mwb_we), .rd(mwb_rd), .rs(rs_vec[g]), .hit(mwb_hit)
    );
    fwd_select u_sel (
      .exm_hit(exm_hit), .mwb_hit(mwb_hit), .sel(sel_vec[g])
    );
    fwd_opmux #(.DATA_W(DATA_W)) u_mux (
      .sel(sel_vec[g]), .rf_val(rf_vec[g]), .exm_val(exm_val),
      .mwb_val(mwb_val), .op(op_vec[g])
    );

    // R1: output value agrees with its select code at the port
    always_comb begin
      if (sel_vec[g] == SEL_EXM) a_r1_exm_path : assert (op_vec[g] == exm_val);
      if (sel_vec[g] == SEL_MWB) a_r1_mwb_path : assert (op_vec[g] == mwb_val);
      if (sel_vec[g] == SEL_RF)  a_r1_rf_path  : assert (op_vec[g] == rf_vec[g]);
    end
  end

  assign sel_a = sel_vec[0];
  assign sel_b = sel_vec[1];
  assign op_a  = op_vec[0];
  assign op_b  = op_vec[1];

  // R2 / R3: a forward from a stage requires that stage's write flag
  always_comb begin
    if (sel_a == 2'b10) a_r2_exm_needs_we : assert (exm_we && exm_rd == rs_a);
    if (sel_b == 2'b01) a_r3_mwb_needs_we : assert (mwb_we && mwb_rd == rs_b);
  end
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  rs_a, rs_b, exm_rd, mwb_rd;
  logic        exm_we, mwb_we;
  logic [31:0] rf_a, rf_b, exm_val, mwb_val;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] op_a, op_b;

  fwd_unit dut_i (
    .rs_a(rs_a), .rs_b(rs_b), .exm_rd(exm_rd), .exm_we(exm_we),
    .mwb_rd(mwb_rd), .mwb_we(mwb_we), .rf_a(rf_a), .rf_b(rf_b),
    .exm_val(exm_val), .mwb_val(mwb_val), .sel_a(sel_a), .sel_b(sel_b),
    .op_a(op_a), .op_b(op_b)
  );

  typedef struct {
    logic [1:0]  sa, sb;
    logic [31:0] va, vb;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [1:0] ref_sel(input logic [4:0] rs);
    // R2, R5, R6 first (newest producer), then R3, else R1 default
    if (exm_we && exm_rd != 5'd0 && exm_rd == rs) return 2'b10;
    if (mwb_we && mwb_rd != 5'd0 && mwb_rd == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] ref_val(input logic [1:0] s, input logic [31:0] rf);
    return (s == 2'b10) ? exm_val : (s == 2'b01) ? mwb_val : rf;
  endfunction

  task automatic drive(input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] erd, input logic ewe,
                       input logic [4:0] mrd, input logic mwe, input string tag);
    exp_t e;
    @(negedge clk);
    rs_a = a; rs_b = b; exm_rd = erd; exm_we = ewe; mwb_rd = mrd; mwb_we = mwe;
    rf_a = $urandom; rf_b = $urandom; exm_val = $urandom; mwb_val = $urandom;
    #0;
    e.sa = ref_sel(a); e.sb = ref_sel(b);
    e.va = ref_val(e.sa, rf_a); e.vb = ref_val(e.sb, rf_b);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  // monitor: sampled at posedge, inputs change only at negedge
  always @(posedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.tag, " sel_a"}, {30'd0, sel_a}, {30'd0, e.sa});
      chk({e.tag, " sel_b"}, {30'd0, sel_b}, {30'd0, e.sb});
      chk({e.tag, " op_a"}, op_a, e.va);
      chk({e.tag, " op_b"}, op_b, e.vb);
      chk("R7 no code 11", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
    end
  end

  initial begin
    rs_a = 0; rs_b = 0; exm_rd = 0; exm_we = 0; mwb_rd = 0; mwb_we = 0;
    rf_a = 0; rf_b = 0; exm_val = 0; mwb_val = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, "R1 idle state");
    drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd9, 1'b1, "R2 back-to-back on A");
    drive(5'd7, 5'd3, 5'd3, 1'b1, 5'd9, 1'b0, "R4 back-to-back on B only");
    drive(5'd3, 5'd4, 5'd3, 1'b0, 5'd9, 1'b0, "R2 exm write flag low");
    drive(5'd8, 5'd2, 5'd1, 1'b1, 5'd8, 1'b1, "R3 two apart on A");
    drive(5'd6, 5'd8, 5'd1, 1'b0, 5'd8, 1'b1, "R4 two apart on B only");
    drive(5'd8, 5'd2, 5'd1, 1'b1, 5'd8, 1'b0, "R3 mwb write flag low");
    drive(5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1, "R6 double match");
    drive(5'd5, 5'd9, 5'd9, 1'b1, 5'd5, 1'b1, "R6 split producers");
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R5 writes to reg 0");
    drive(5'd0, 5'd4, 5'd0, 1'b1, 5'd4, 1'b1, "R5 reg 0 exm with mwb on B");
    drive(5'd31, 5'd31, 5'd31, 1'b1, 5'd2, 1'b1, "R8 top register");
    for (int i = 0; i < 400; i++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)),
            1'($urandom), "R8 random sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    for (int t = 0; t < 5000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule